// File: doc/BRIEF.md
# Threshold-Based Write Redirection Controller

This block is the write front end of a small flash store. A host write carries a 25-bit address and one data byte. The controller turns the logical block number in the address into a physical block through a block-wise mapping table. It then places the byte in that physical block and adds one to that block's write count. While the count stays below a programmable saturation level, writes stay where they are. Relocation of data is put off until then.

When a write targets a block whose count has reached the saturation level, the controller picks the least-written other user block that still has room. It exchanges the contents of the two blocks by way of a spare block that the host cannot address, swaps their table entries, records the redirection in the saturated block's link field, and then completes the write in the fresh block. A write is refused only when no block has room. This lets writes that all hit one logical block be accepted S×B times. Reads are answered from the mapped location, and only while no write is being processed.

Top module: `wear_redirect`

## Requirements
- R1: After reset, the busy flag is low, every stored byte reads as zero, and the counter word of physical block i shows resident block i, count 0 and link i.
- R2: Address bits [4:3] select the logical block, bit [2] the page and bits [1:0] the byte within the page. Bits [24:5] are not decoded, so addresses that differ only there reach the same byte. A read returns the byte last written there.
- R3: The counter word of a physical block holds the logical block currently stored in it in bits [13:12], its count of served host writes in bits [11:2] and its link in bits [1:0]. Each accepted write adds exactly one to the count of the block that receives it. Migration copies do not change any count.
- R4: A write to a logical block whose physical block has count ≥ saturation level goes to the other user block with the smallest count below the level, with ties going to the lowest index. The two blocks exchange contents and mapping entries, the saturated block's link takes the chosen index, and the data of both logical blocks is preserved.
- R5: With saturation level S, writes that all target one logical block are accepted S×4 times. Every later write is refused and leaves the stored data unchanged. A level of 0 refuses every write.
- R6: Every write request taken in ends in exactly one completion pulse: wr_done when accepted, wr_full when refused, never both.
- R7: busy is high from the cycle after a write is taken in until its completion pulse has passed. A read request made while busy is not answered. In the idle state rd_valid rises one cycle after rd_req.
- R8: A write request made while busy is ignored: it writes no byte and changes no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sat_level | input | 10 | Saturation level per block, held stable during operation |
| wr_req | input | 1 | Write request, taken only while idle |
| wr_addr | input | 25 | Write byte address |
| wr_data | input | 8 | Write data byte |
| rd_req | input | 1 | Read request, served only while idle with no write request |
| rd_addr | input | 25 | Read byte address |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | One-cycle pulse marking a served read |
| busy | output | 1 | A write is being processed |
| wr_done | output | 1 | One-cycle pulse: write accepted and stored |
| wr_full | output | 1 | One-cycle pulse: write refused, every block saturated |
| cnt_sel | input | 2 | Physical block whose counter word is shown |
| cnt_word | output | 14 | Counter word of the selected physical block |

## Verification
The hardest state to reach from the ports is the one where every user block has reached the saturation level while the data moved by earlier exchanges is still intact. Only then does the refusal path run, and only after a chain of exchanges that each picked a different victim. The bench reaches it by sending a long stream of writes to a single logical block, which forces one exchange per saturation. It then reads the last bytes back and checks every counter word. A short run with a low level and unequal counts checks the tie-break and the link and residency fields after a single exchange.

// File: rtl/wl_pkg.sv
// Shared types for the write redirection controller.
package wl_pkg;

    // Control sequence of one write request.
    typedef enum logic [3:0] {
        ST_IDLE,    // wait for a request, serve reads
        ST_LOOKUP,  // translate logical block to physical block
        ST_CHECK,   // compare the block count with the saturation level
        ST_SELECT,  // choose the least-written fresh block
        ST_MOVE_A,  // victim block -> spare block
        ST_MOVE_B,  // saturated block -> victim block
        ST_MOVE_C,  // spare block -> saturated block, commit remap
        ST_WRITE,   // store the byte, bump the count
        ST_DONE,    // accepted completion pulse
        ST_REJECT   // refused completion pulse
    } wl_state_t;

endpackage

// File: rtl/wl_block_store.sv
// Behavioural storage array: NPHYS physical blocks of BLK_BYTES bytes.
// One write port and two combinational read ports (copy and host).
// Assumes BLK_BYTES is a power of two, so {block, offset} is a dense address.
module wl_block_store #(
    parameter int NPHYS     = 5,
    parameter int BLK_BYTES = 8,
    parameter int DATA_W    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [$clog2(NPHYS)-1:0]     wblk,
    input  logic [$clog2(BLK_BYTES)-1:0] woff,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [$clog2(NPHYS)-1:0]     ablk,
    input  logic [$clog2(BLK_BYTES)-1:0] aoff,
    output logic [DATA_W-1:0]            adata,
    input  logic [$clog2(NPHYS)-1:0]     bblk,
    input  logic [$clog2(BLK_BYTES)-1:0] boff,
    output logic [DATA_W-1:0]            bdata
);
    localparam int PHYS_W = $clog2(NPHYS);
    localparam int OFF_W  = $clog2(BLK_BYTES);
    localparam int AW     = PHYS_W + OFF_W;
    localparam int DEPTH  = NPHYS * BLK_BYTES;

    logic [DATA_W-1:0] mem [0:DEPTH-1];
    logic [AW-1:0]     waddr, aaddr, baddr;

    assign waddr = {wblk, woff};
    assign aaddr = {ablk, aoff};
    assign baddr = {bblk, boff};

    // Clear on reset, otherwise store one byte per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Combinational read ports.
    assign adata = mem[aaddr];
    assign bdata = mem[baddr];

endmodule

// File: rtl/wl_min_select.sv
// Least-count search over the user blocks. A block is eligible when it is not
// the excluded block and its count is below the limit. Ties go to the lowest
// index. Purely combinational.
module wl_min_select #(
    parameter int NBLK  = 4,
    parameter int CNT_W = 10
) (
    input  logic [NBLK*CNT_W-1:0]   cnt_flat,
    input  logic [$clog2(NBLK)-1:0] excl,
    input  logic [CNT_W-1:0]        limit,
    output logic                    found,
    output logic [$clog2(NBLK)-1:0] pick
);
    localparam int BLK_W = $clog2(NBLK);

    logic [NBLK-1:0]  elig;
    logic [CNT_W-1:0] best;

    // Eligibility flag per block.
    for (genvar g = 0; g < NBLK; g++) begin : g_elig
        assign elig[g] = (BLK_W'(g) != excl) && (cnt_flat[g*CNT_W +: CNT_W] < limit);
    end

    // Scan low to high, a strict compare keeps the lowest index on ties.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        best  = '0;
        for (int i = 0; i < NBLK; i++) begin
            if (elig[i] && (!found || cnt_flat[i*CNT_W +: CNT_W] < best)) begin
                found = 1'b1;
                pick  = BLK_W'(i);
                best  = cnt_flat[i*CNT_W +: CNT_W];
            end
        end
    end

endmodule

// File: rtl/wear_redirect.sv
// Threshold-based write redirection controller. Translates logical blocks to
// physical blocks, counts host writes per block, and when a block's count has
// reached sat_level exchanges it with the least-written fresh block through a
// spare block before completing the write. Assumes NBLK and BLK_BYTES are
// powers of two and sat_level is held stable while busy.
module wear_redirect #(
    parameter int NBLK       = 4,
    parameter int PAGES      = 2,
    parameter int PAGE_BYTES = 4,
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 25,
    parameter int CNT_W      = 10
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [CNT_W-1:0]                    sat_level,
    input  logic                                wr_req,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [DATA_W-1:0]                   wr_data,
    input  logic                                rd_req,
    input  logic [ADDR_W-1:0]                   rd_addr,
    output logic [DATA_W-1:0]                   rd_data,
    output logic                                rd_valid,
    output logic                                busy,
    output logic                                wr_done,
    output logic                                wr_full,
    input  logic [$clog2(NBLK)-1:0]             cnt_sel,
    output logic [2*$clog2(NBLK)+CNT_W-1:0]     cnt_word
);
    import wl_pkg::*;

    localparam int BLK_BYTES = PAGES * PAGE_BYTES;
    localparam int OFF_W     = $clog2(BLK_BYTES);
    localparam int BLK_W     = $clog2(NBLK);
    localparam int NPHYS     = NBLK + 1;
    localparam int PHYS_W    = $clog2(NPHYS);
    localparam int HI_LSB    = OFF_W + BLK_W;
    localparam logic [PHYS_W-1:0] SPARE = PHYS_W'(NBLK);
    localparam logic [OFF_W-1:0]  LAST  = OFF_W'(BLK_BYTES - 1);

    wl_state_t         state;
    logic [BLK_W-1:0]  lblk_r, phys_r, vict_r;
    logic [OFF_W-1:0]  off_r, idx;
    logic [DATA_W-1:0] data_r;
    logic [BLK_W-1:0]  map_t   [NBLK];
    logic [BLK_W-1:0]  owner_t [NBLK];
    logic [BLK_W-1:0]  link_t  [NBLK];
    logic [CNT_W-1:0]  cnt     [NBLK];
    logic [NBLK*CNT_W-1:0] cnt_flat;

    logic              sel_found;
    logic [BLK_W-1:0]  sel_pick;
    logic              st_we;
    logic [PHYS_W-1:0] st_wblk, cp_blk, hr_blk;
    logic [OFF_W-1:0]  st_woff;
    logic [DATA_W-1:0] st_wdata, cp_data, hr_data;
    logic [BLK_W-1:0]  rd_lblk;
    logic              unused_addr_hi;

    // Upper address bits are outside the decoded range.
    assign unused_addr_hi = ^{wr_addr[ADDR_W-1:HI_LSB], rd_addr[ADDR_W-1:HI_LSB]};

    // Flatten the counters for the search and the checker.
    for (genvar g = 0; g < NBLK; g++) begin : g_flat
        assign cnt_flat[g*CNT_W +: CNT_W] = cnt[g];
    end

    wl_min_select #(.NBLK(NBLK), .CNT_W(CNT_W)) u_sel (
        .cnt_flat (cnt_flat),
        .excl     (phys_r),
        .limit    (sat_level),
        .found    (sel_found),
        .pick     (sel_pick)
    );

    // Host read path goes through the mapping table.
    assign rd_lblk = rd_addr[OFF_W +: BLK_W];
    assign hr_blk  = PHYS_W'(map_t[rd_lblk]);

    wl_block_store #(.NPHYS(NPHYS), .BLK_BYTES(BLK_BYTES), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_we),
        .wblk  (st_wblk),
        .woff  (st_woff),
        .wdata (st_wdata),
        .ablk  (cp_blk),
        .aoff  (idx),
        .adata (cp_data),
        .bblk  (hr_blk),
        .boff  (rd_addr[OFF_W-1:0]),
        .bdata (hr_data)
    );

    // Steer the storage write port for the copy phases and the host write.
    always_comb begin
        st_we    = 1'b0;
        st_wblk  = PHYS_W'(phys_r);
        st_woff  = idx;
        st_wdata = cp_data;
        cp_blk   = PHYS_W'(vict_r);
        case (state)
            ST_MOVE_A: begin
                st_we   = 1'b1;
                st_wblk = SPARE;
                cp_blk  = PHYS_W'(vict_r);
            end
            ST_MOVE_B: begin
                st_we   = 1'b1;
                st_wblk = PHYS_W'(vict_r);
                cp_blk  = PHYS_W'(phys_r);
            end
            ST_MOVE_C: begin
                st_we   = 1'b1;
                st_wblk = PHYS_W'(phys_r);
                cp_blk  = SPARE;
            end
            ST_WRITE: begin
                st_we    = 1'b1;
                st_woff  = off_r;
                st_wdata = data_r;
            end
            default: ;
        endcase
    end

    // Control sequence, table, counters and read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            lblk_r   <= '0;
            phys_r   <= '0;
            vict_r   <= '0;
            off_r    <= '0;
            idx      <= '0;
            data_r   <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            for (int i = 0; i < NBLK; i++) begin
                map_t[i]   <= BLK_W'(i);
                owner_t[i] <= BLK_W'(i);
                link_t[i]  <= BLK_W'(i);
                cnt[i]     <= '0;
            end
        end else begin
            rd_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (wr_req) begin
                        lblk_r <= wr_addr[OFF_W +: BLK_W];
                        off_r  <= wr_addr[OFF_W-1:0];
                        data_r <= wr_data;
                        state  <= ST_LOOKUP;
                    end else if (rd_req) begin
                        rd_valid <= 1'b1;
                        rd_data  <= hr_data;
                    end
                end
                ST_LOOKUP: begin
                    phys_r <= map_t[lblk_r];
                    state  <= ST_CHECK;
                end
                ST_CHECK: begin
                    state <= (cnt[phys_r] < sat_level) ? ST_WRITE : ST_SELECT;
                end
                ST_SELECT: begin
                    idx <= '0;
                    if (sel_found) begin
                        vict_r <= sel_pick;
                        state  <= ST_MOVE_A;
                    end else begin
                        state  <= ST_REJECT;
                    end
                end
                ST_MOVE_A: begin
                    idx <= idx + 1'b1;
                    if (idx == LAST) state <= ST_MOVE_B;
                end
                ST_MOVE_B: begin
                    idx <= idx + 1'b1;
                    if (idx == LAST) state <= ST_MOVE_C;
                end
                ST_MOVE_C: begin
                    idx <= idx + 1'b1;
                    if (idx == LAST) begin
                        map_t[lblk_r]          <= vict_r;
                        map_t[owner_t[vict_r]] <= phys_r;
                        owner_t[vict_r]        <= lblk_r;
                        owner_t[phys_r]        <= owner_t[vict_r];
                        link_t[phys_r]         <= vict_r;
                        phys_r                 <= vict_r;
                        state                  <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    cnt[phys_r] <= cnt[phys_r] + 1'b1;
                    state       <= ST_DONE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Status outputs and the selected counter word.
    assign busy     = (state != ST_IDLE);
    assign wr_done  = (state == ST_DONE);
    assign wr_full  = (state == ST_REJECT);
    assign cnt_word = {owner_t[cnt_sel], cnt[cnt_sel], link_t[cnt_sel]};

endmodule

// File: rtl/wl_ctrl_chk.sv
// Protocol and counter checks for wear_redirect, attached with bind.
module wl_ctrl_chk #(
    parameter int NBLK  = 4,
    parameter int CNT_W = 10
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_req,
    input logic                  busy,
    input logic                  wr_done,
    input logic                  wr_full,
    input logic                  rd_valid,
    input logic [NBLK*CNT_W-1:0] cnt_flat
);
    // R3: a count only ever moves up by one.
    for (genvar g = 0; g < NBLK; g++) begin : g_cnt
        a_r3_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_flat[g*CNT_W +: CNT_W] != $past(cnt_flat[g*CNT_W +: CNT_W]))
            |-> (cnt_flat[g*CNT_W +: CNT_W] == $past(cnt_flat[g*CNT_W +: CNT_W]) + 1'b1));
    end

    // R6: accepted and refused pulses never coincide.
    a_r6_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_done && wr_full));

    // R6: a completion pulse is followed by idle.
    a_r6_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done || wr_full) |=> !busy);

    // R7: busy starts only from a write request.
    a_r7_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_req));

    // R7: busy ends only after a completion pulse.
    a_r7_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(wr_done || wr_full));

    // R7: no read is answered while a write is in progress.
    a_r7_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !busy);

endmodule

bind wear_redirect wl_ctrl_chk #(.NBLK(NBLK), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (wr_req),
    .busy     (busy),
    .wr_done  (wr_done),
    .wr_full  (wr_full),
    .rd_valid (rd_valid),
    .cnt_flat (cnt_flat)
);

// File: tb/wear_redirect_test.sv
// Directed bench for wear_redirect: one task per scenario.
module wear_redirect_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [9:0]  sat_level;
    logic        wr_req, rd_req;
    logic [24:0] wr_addr, rd_addr;
    logic [7:0]  wr_data, rd_data;
    logic        rd_valid, busy, wr_done, wr_full;
    logic [1:0]  cnt_sel;
    logic [13:0] cnt_word;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    wear_redirect uut (
        .clk(clk), .rst_n(rst_n), .sat_level(sat_level),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .busy(busy), .wr_done(wr_done), .wr_full(wr_full),
        .cnt_sel(cnt_sel), .cnt_word(cnt_word)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [24:0] mk(input int lb, input int off);
        return 25'((lb << 3) | off);
    endfunction

    function automatic logic [13:0] word(input int id, input int c, input int l);
        return {id[1:0], c[9:0], l[1:0]};
    endfunction

    task automatic do_reset(input int sat);
        @(negedge clk);
        rst_n = 1'b0; wr_req = 1'b0; rd_req = 1'b0; sat_level = 10'(sat);
        wr_addr = '0; wr_data = '0; rd_addr = '0; cnt_sel = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Returns 1 accepted, 2 refused, 0 malformed or hung.
    task automatic do_write(input logic [24:0] a, input logic [7:0] d, output int res);
        int nd = 0, nf = 0;
        @(negedge clk);
        wr_req = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_req = 1'b0;
        for (int t = 0; t < 400; t++) begin
            if (wr_done) nd++;
            if (wr_full) nf++;
            if (!busy) break;
            @(negedge clk);
        end
        res = (nd == 1 && nf == 0) ? 1 : (nf == 1 && nd == 0) ? 2 : 0;
    endtask

    task automatic do_read(input logic [24:0] a, output logic [7:0] d, output logic v);
        @(negedge clk);
        rd_req = 1'b1; rd_addr = a;
        @(negedge clk);
        v = rd_valid; d = rd_data;
        rd_req = 1'b0;
    endtask

    task automatic get_word(input int p, output logic [13:0] w);
        cnt_sel = 2'(p);
        #1;
        w = cnt_word;
    endtask

    task automatic t_reset;
        logic [13:0] w; logic [7:0] d; logic v;
        do_reset(16);
        check("R1 busy", busy, 0);
        for (int i = 0; i < 4; i++) begin
            get_word(i, w);
            check("R1 counter word", w, word(i, 0, i));
        end
        do_read(mk(2, 6), d, v);
        check("R7 read valid", v, 1);
        check("R1 cleared byte", d, 8'h00);
    endtask

    task automatic t_basic;
        int r; logic [13:0] w; logic [7:0] d; logic v;
        do_reset(16);
        do_write(mk(2, 5), 8'hA5, r);
        check("R6 accepted pulse", r, 1);
        do_read(mk(2, 5), d, v);
        check("R2 read back", d, 8'hA5);
        do_read(mk(2, 5) | 25'h1000400, d, v);
        check("R2 alias read", d, 8'hA5);
        do_write(mk(1, 0) | 25'h0800020, 8'h5C, r);
        do_read(mk(1, 0), d, v);
        check("R2 alias write", d, 8'h5C);
        do_read(mk(1, 4), d, v);
        check("R2 page select", d, 8'h00);
        get_word(2, w);
        check("R3 count of block 2", w, word(2, 1, 2));
        get_word(1, w);
        check("R3 count of block 1", w, word(1, 1, 1));
    endtask

    task automatic t_busy;
        logic [13:0] w; logic [7:0] d; logic v;
        int seen_rd = 0, seen_done = 0;
        do_reset(16);
        @(negedge clk);
        wr_req = 1'b1; wr_addr = mk(3, 1); wr_data = 8'h3A;
        @(negedge clk);
        check("R7 busy after request", busy, 1);
        rd_req = 1'b1; rd_addr = mk(3, 1);
        wr_addr = mk(3, 2); wr_data = 8'h99;
        for (int t = 0; t < 50; t++) begin
            if (rd_valid) seen_rd++;
            if (wr_done) begin seen_done = 1; break; end
            @(negedge clk);
        end
        rd_req = 1'b0; wr_req = 1'b0;
        while (busy) @(negedge clk);
        check("R7 no read while busy", seen_rd, 0);
        check("R6 done seen", seen_done, 1);
        do_read(mk(3, 2), d, v);
        check("R8 ignored write byte", d, 8'h00);
        do_read(mk(3, 1), d, v);
        check("R8 first write kept", d, 8'h3A);
        get_word(3, w);
        check("R8 one count only", w, word(3, 1, 3));
    endtask

    task automatic t_redirect;
        int r; logic [13:0] w; logic [7:0] d; logic v;
        do_reset(3);
        do_write(mk(1, 7), 8'h71, r);
        for (int k = 0; k < 3; k++) do_write(mk(0, k), 8'(8'h10 + k), r);
        do_write(mk(0, 3), 8'h13, r);
        check("R4 write after saturation accepted", r, 1);
        for (int k = 0; k < 4; k++) begin
            do_read(mk(0, k), d, v);
            check("R4 hot data kept", d, 8'(8'h10 + k));
        end
        do_read(mk(1, 7), d, v);
        check("R4 cold data kept", d, 8'h71);
        do_read(mk(2, 0), d, v);
        check("R4 swapped block data", d, 8'h00);
        get_word(0, w);
        check("R4 saturated block word", w, word(2, 3, 2));
        get_word(2, w);
        check("R4 tie to lowest index", w, word(0, 1, 2));
        get_word(1, w);
        check("R4 untouched block", w, word(1, 1, 1));
    endtask

    task automatic t_capacity;
        int r, acc = 0; logic [13:0] w; logic [7:0] d; logic v;
        do_reset(16);
        for (int k = 0; k < 64; k++) begin
            do_write(mk(0, k % 8), 8'(k), r);
            if (r == 1) acc++;
        end
        check("R5 accepted up to S x B", acc, 64);
        do_write(mk(0, 0), 8'hEE, r);
        check("R5 refused when full", r, 2);
        do_write(mk(2, 3), 8'hEE, r);
        check("R5 other block refused", r, 2);
        for (int k = 0; k < 8; k++) begin
            do_read(mk(0, k), d, v);
            check("R5 data unchanged", d, 8'(56 + k));
        end
        do_read(mk(2, 3), d, v);
        check("R5 refused byte absent", d, 8'h00);
        for (int p = 0; p < 4; p++) begin
            get_word(p, w);
            check("R3 saturated count", w[11:2], 16);
        end
    endtask

    task automatic t_zero;
        int r; logic [13:0] w; logic [7:0] d; logic v;
        do_reset(0);
        do_write(mk(1, 2), 8'h42, r);
        check("R5 level zero refuses", r, 2);
        do_read(mk(1, 2), d, v);
        check("R5 level zero no data", d, 8'h00);
        get_word(1, w);
        check("R5 level zero no count", w, word(1, 0, 1));
    endtask

    task automatic finish_run;
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        rst_n = 1'b0; wr_req = 1'b0; rd_req = 1'b0; sat_level = 10'd16;
        wr_addr = '0; wr_data = '0; rd_addr = '0; cnt_sel = '0;
        t_reset;
        t_basic;
        t_busy;
        t_redirect;
        t_capacity;
        t_zero;
        finish_run;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run;
    end

endmodule